// File: doc/BRIEF.md
# Memory Read Streamer

The streamer fetches a run of consecutive 128-bit words from an external memory read port and forwards them to a host-bound DMA write port as a stream of 64-bit elements. A run is started with a one-cycle start pulse. The same cycle supplies a base word address and the number of 64-bit elements wanted. The block issues word reads beginning at the base address. It places returned words in an internal buffer and then emits each word as two elements: the high half first, then the low half.

Backpressure can come from either side. The memory port may refuse a request by holding its ready-for-input flag low. The DMA port may fail to complete a write by holding its ready low, which covers both not-ready and timeout. In either case the block holds what it is presenting and retries. The block counts read requests that are in flight and words that are buffered. It issues a new request only when the request limit and the buffer both leave room. A stalled DMA port therefore stops memory traffic without losing or repeating an element. When the last element has been written, a done flag rises and stays high until the next run.

Top module: `mem_read_streamer`

## Requirements
- R1: The number of read requests accepted but not yet answered by a data-valid strobe never exceeds MAX_OUT (default 32). This holds even when the memory port keeps its ready flag high.
- R2: A request is taken only in a cycle where request-valid and memory ready are both high. While valid is high and ready is low, valid stays high and the address does not change.
- R3: The first request of a run carries the base address. Each accepted request advances the address by exactly one, wrapping modulo 2^ADDR_W.
- R4: Words are forwarded in request order. Each word becomes two elements: bits [127:64] first, then bits [63:0].
- R5: When the DMA port does not accept an element, dma_valid stays high and dma_data is unchanged until the element is accepted.
- R6: Accepted-but-unanswered requests plus buffered words never exceed FIFO_DEPTH (default 32). With the DMA port fully stalled, exactly FIFO_DEPTH requests are accepted and no more.
- R7: done rises in the cycle after the final element is accepted and stays high. While done is high, neither mem_req_valid nor dma_valid is asserted.
- R8: For an element count N, exactly ceil(N/2) words are requested. When N is odd, only the high half of the last word is sent.
- R9: A start with element count 0 raises done in the next cycle and issues no request and no element.
- R10: A start pulse during a run is ignored. The run goes on with its original address and count.
- R11: Reset, including reset in the middle of a run, returns the block to idle with mem_req_valid, dma_valid and done low, and discards buffered words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| base_addr | input | ADDR_W | First word address of the run, sampled with start |
| elem_count | input | CNT_W | Number of 64-bit elements in the run, sampled with start |
| mem_req_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory ready-for-input flag |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_rvalid | input | 1 | Returned word valid strobe |
| mem_rdata | input | 128 | Returned word |
| dma_valid | output | 1 | Element valid toward the DMA port |
| dma_ready | input | 1 | DMA write completes this cycle (low means stall or timeout) |
| dma_data | output | 64 | Current 64-bit element |
| done | output | 1 | Run finished; held until the next start |

## Verification
The in-RTL properties are checked on every cycle. They cover the in-flight bound and credit bound, request hold under a low ready flag, the address step per accepted request, element hold under DMA stall, buffer overflow and underflow, and the silence of both ports once done is high. Other behaviour only the bench scenarios can show, since it depends on values across a whole run. This covers data order and content, the odd-count tail, the zero-count run, the exact request count when the DMA port never accepts, a start ignored during a run, and a clean run after a mid-run reset.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int unsigned HALF_W = 64;
    localparam int unsigned WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_DONE = 2'd2
    } run_state_e;

endpackage

// File: rtl/mrs_req_issuer.sv
module mrs_req_issuer #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MAX_OUT    = 32,
    parameter int unsigned FIFO_DEPTH = 32,
    localparam int unsigned OUT_W     = $clog2(MAX_OUT + 1),
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_total,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int unsigned SUM_W = ((OUT_W > LVL_W) ? OUT_W : LVL_W) + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [OUT_W-1:0]  inflight;
    } iss_state_t;

    iss_state_t st_q, st_d;

    logic             slot_free;
    logic             room_free;
    logic             accept;
    logic [SUM_W-1:0] credit_used;

    always_comb begin
        credit_used   = SUM_W'(st_q.inflight) + SUM_W'(fifo_level);
        slot_free     = st_q.inflight < OUT_W'(MAX_OUT);
        room_free     = credit_used < SUM_W'(FIFO_DEPTH);
        mem_req_valid = (st_q.left != '0) && slot_free && room_free;
        accept        = mem_req_valid && mem_ready;
        mem_addr      = st_q.addr;

        st_d = st_q;
        if (launch) begin
            st_d.addr = base_addr;
            st_d.left = word_total;
        end else if (accept) begin
            st_d.addr = st_q.addr + ADDR_W'(1);
            st_d.left = st_q.left - CNT_W'(1);
        end
        case ({accept, mem_rvalid})
            2'b10:   st_d.inflight = st_q.inflight + OUT_W'(1);
            2'b01:   st_d.inflight = st_q.inflight - OUT_W'(1);
            default: st_d.inflight = st_q.inflight;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: in-flight requests stay within the hard limit
    p_inflight_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inflight <= OUT_W'(MAX_OUT));

    // R1: a returned word always has a request waiting for it
    p_return_has_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (st_q.inflight != '0));

    // R2: a refused request is held with the same address
    p_request_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R3: each accepted request moves the address by one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ready) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R6: outstanding plus buffered never exceeds the buffer
    p_credit_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        credit_used <= SUM_W'(FIFO_DEPTH));

endmodule

// File: rtl/mrs_word_fifo.sv
module mrs_word_fifo #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WIDTH  = 128,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] lvl;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic [WIDTH-1:0] store [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        empty = (st_q.lvl == '0);
        level = st_q.lvl;
        dout  = store[st_q.rd];

        st_d = st_q;
        if (push) st_d.wr = ptr_next(st_q.wr);
        if (pop)  st_d.rd = ptr_next(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.lvl = st_q.lvl + LVL_W'(1);
            2'b01:   st_d.lvl = st_q.lvl - LVL_W'(1);
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            store[st_q.wr] <= din;
        end
    end

    // R6: a returned word always finds a free entry
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.lvl < LVL_W'(DEPTH)));

    // R6: nothing is taken from an empty buffer
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.lvl != '0));

endmodule

// File: rtl/mrs_half_sender.sv
module mrs_half_sender
    import mrs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  elem_total,
    input  logic              head_valid,
    input  logic [WORD_W-1:0] head_word,
    input  logic              dma_ready,
    output logic              dma_valid,
    output logic [HALF_W-1:0] dma_data,
    output logic              pop,
    output logic              launch,
    output logic              done
);

    typedef struct packed {
        run_state_e       run;
        logic             low_half;
        logic [CNT_W-1:0] left;
    } snd_state_t;

    snd_state_t st_q, st_d;

    logic fire;
    logic last_elem;

    always_comb begin
        launch    = start && (st_q.run != RUN_BUSY);
        dma_valid = (st_q.run == RUN_BUSY) && head_valid;
        dma_data  = st_q.low_half ? head_word[HALF_W-1:0] : head_word[WORD_W-1:HALF_W];
        done      = (st_q.run == RUN_DONE);
        fire      = dma_valid && dma_ready;
        last_elem = (st_q.left == CNT_W'(1));
        pop       = fire && (st_q.low_half || last_elem);

        st_d = st_q;
        if (launch) begin
            st_d.low_half = 1'b0;
            st_d.left     = elem_total;
            st_d.run      = (elem_total == '0) ? RUN_DONE : RUN_BUSY;
        end else if (fire) begin
            st_d.left     = st_q.left - CNT_W'(1);
            st_d.low_half = !pop;
            if (last_elem) st_d.run = RUN_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: RUN_IDLE, low_half: 1'b0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a stalled element is presented again unchanged
    p_element_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_data)));

endmodule

// File: rtl/mem_read_streamer.sv
module mem_read_streamer
    import mrs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MAX_OUT    = 32,
    parameter int unsigned FIFO_DEPTH = 32,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  elem_count,
    output logic              mem_req_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [HALF_W-1:0] dma_data,
    output logic              done
);

    logic              launch;
    logic              pop;
    logic              fifo_empty;
    logic [LVL_W-1:0]  fifo_level;
    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  word_total;

    assign word_total = CNT_W'(({1'b0, elem_count} + (CNT_W + 1)'(1)) >> 1);

    mrs_req_issuer #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .MAX_OUT   (MAX_OUT),
        .FIFO_DEPTH(FIFO_DEPTH)
    ) i_issuer (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .base_addr    (base_addr),
        .word_total   (word_total),
        .mem_ready    (mem_ready),
        .mem_rvalid   (mem_rvalid),
        .fifo_level   (fifo_level),
        .mem_req_valid(mem_req_valid),
        .mem_addr     (mem_addr)
    );

    mrs_word_fifo #(
        .DEPTH(FIFO_DEPTH),
        .WIDTH(WORD_W)
    ) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (mem_rvalid),
        .din  (mem_rdata),
        .pop  (pop),
        .dout (head_word),
        .empty(fifo_empty),
        .level(fifo_level)
    );

    mrs_half_sender #(
        .CNT_W(CNT_W)
    ) i_sender (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .elem_total(elem_count),
        .head_valid(!fifo_empty),
        .head_word (head_word),
        .dma_ready (dma_ready),
        .dma_valid (dma_valid),
        .dma_data  (dma_data),
        .pop       (pop),
        .launch    (launch),
        .done      (done)
    );

    // R7: once finished, both ports stay quiet
    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req_valid && !dma_valid));

endmodule

// File: tb/test_mem_read_streamer.sv
module test_mem_read_streamer;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int LIMIT  = 32;
    localparam int DEPTH  = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              start;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  elem_count;
    logic              mem_req_valid;
    logic              mem_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid;
    logic [127:0]      mem_rdata;
    logic              dma_valid;
    logic              dma_ready;
    logic [63:0]       dma_data;
    logic              done;

    mem_read_streamer i_mem_read_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .elem_count(elem_count), .mem_req_valid(mem_req_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int unsigned p_mready = 100, p_dready = 100, p_ret = 100, lat = 2;
    bit          limit_en = 1'b1;

    logic [31:0] exp_base = '0;
    int          exp_count = 0;
    int          elem_idx = 0, acc_count = 0, released = 0, outstanding = 0, max_out = 0;
    bit          over_credit = 0, done_due = 0, seeded = 0;
    bit          prev_req_wait = 0, prev_dma_wait = 0;
    logic [31:0] prev_addr = '0;
    logic [63:0] prev_data = '0;
    logic [31:0] q_addr[$];
    int          q_due[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mem_word(input logic [31:0] a);
        return {a ^ 32'hC0DE_0000, ~a, a * 32'd7 + 32'h1234, {a[15:0], a[31:16]}};
    endfunction

    function automatic logic [63:0] exp_elem(input logic [31:0] base, input int i);
        logic [127:0] w;
        w = mem_word(base + 32'(i / 2));
        return (i % 2 == 0) ? w[127:64] : w[63:0];
    endfunction

    // memory and DMA models, plus per-cycle checks
    always @(negedge clk) begin
        if (!seeded) begin
            void'($urandom(32'd4711));
            seeded = 1;
        end
        cyc++;
        if (!rst_n) begin
            mem_ready = 0; mem_rvalid = 0; mem_rdata = '0; dma_ready = 0;
            prev_req_wait = 0; prev_dma_wait = 0; done_due = 0;
        end else begin
            if (done_due) begin
                check(done === 1'b1, "R7", "done after final element", 64'(done), 64'd1);
                done_due = 0;
            end
            mem_rvalid = 0;
            if (q_addr.size() > 0 && q_due[0] <= cyc && ($urandom % 100) < p_ret) begin
                mem_rvalid = 1;
                mem_rdata  = mem_word(q_addr[0]);
                void'(q_addr.pop_front());
                void'(q_due.pop_front());
                outstanding--;
            end
            mem_ready = (($urandom % 100) < p_mready) && (!limit_en || outstanding < LIMIT);
            dma_ready = ($urandom % 100) < p_dready;
            #1;
            if (prev_req_wait)
                check(mem_req_valid && mem_addr == prev_addr, "R2", "refused request held",
                      64'(mem_addr), 64'(prev_addr));
            if (prev_dma_wait)
                check(dma_valid && dma_data == prev_data, "R5", "stalled element held",
                      dma_data, prev_data);
            if (mem_req_valid && mem_ready) begin
                check(mem_addr == exp_base + 32'(acc_count), "R3", "request address",
                      64'(mem_addr), 64'(exp_base + 32'(acc_count)));
                q_addr.push_back(mem_addr);
                q_due.push_back(cyc + int'(lat) + int'($urandom % 3));
                acc_count++;
                outstanding++;
                if (outstanding > max_out) max_out = outstanding;
            end
            if (dma_valid) begin
                if (elem_idx >= exp_count) begin
                    check(0, "R7", "element beyond count", 64'(elem_idx), 64'(exp_count));
                end else if (dma_ready) begin
                    check(dma_data == exp_elem(exp_base, elem_idx), "R4", "element value",
                          dma_data, exp_elem(exp_base, elem_idx));
                    if (elem_idx % 2 == 1 || elem_idx == exp_count - 1) released++;
                    elem_idx++;
                    if (elem_idx == exp_count) done_due = 1;
                end
            end
            if (acc_count - released > DEPTH) over_credit = 1;
            prev_req_wait = mem_req_valid && !mem_ready;
            prev_addr     = mem_addr;
            prev_dma_wait = dma_valid && !dma_ready;
            prev_data     = dma_data;
        end
    end

    task automatic launch_run(input logic [31:0] base, input int count);
        @(negedge clk);
        exp_base = base; exp_count = count;
        elem_idx = 0; acc_count = 0; released = 0; over_credit = 0; max_out = 0;
        base_addr = base; elem_count = CNT_W'(count); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic finish_run(input string name);
        int n = 0;
        int a0, e0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
        end
        #2;
        check(elem_idx == exp_count, "R4", {name, " all elements sent"}, 64'(elem_idx), 64'(exp_count));
        check(acc_count == (exp_count + 1) / 2, "R8", {name, " word requests"},
              64'(acc_count), 64'((exp_count + 1) / 2));
        check(!over_credit, "R6", {name, " credit bound"}, 64'(over_credit), 64'd0);
        a0 = acc_count; e0 = elem_idx;
        repeat (10) @(negedge clk);
        #2;
        check(acc_count == a0 && elem_idx == e0 && done, "R7", {name, " quiet after done"},
              64'(acc_count + elem_idx), 64'(a0 + e0));
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start = 0; base_addr = '0; elem_count = '0;
        repeat (5) @(negedge clk);
        #2;
        check(!mem_req_valid && !dma_valid && !done, "R11", "reset state",
              {61'd0, mem_req_valid, dma_valid, done}, 64'd0);
        @(negedge clk);
        rst_n = 1;

        // single element: odd tail, high half only
        launch_run(32'h0000_1000, 1);
        finish_run("R8 count1");

        // short even run, no stalls
        launch_run(32'h0000_2000, 8);
        finish_run("R4 count8");

        // odd count with stalls
        p_dready = 50;
        launch_run(32'h0000_3000, 7);
        finish_run("R8 count7");
        p_dready = 100;

        // zero count
        launch_run(32'h0000_4000, 0);
        #2;
        check(done === 1'b1, "R9", "done one cycle after zero start", 64'(done), 64'd1);
        finish_run("R9 count0");

        // address wrap across the top of the space
        launch_run(32'hFFFF_FFF8, 30);
        finish_run("R3 wrap");

        // DMA fully stalled: requests stop at buffer room
        p_dready = 0;
        launch_run(32'h0001_0000, 200);
        repeat (200) @(negedge clk);
        #2;
        check(acc_count == DEPTH, "R6", "requests under full stall", 64'(acc_count), 64'(DEPTH));
        check(elem_idx == 0 && dma_valid, "R5", "element pending under stall",
              64'(elem_idx), 64'd0);
        p_dready = 100;
        finish_run("R6 stall");

        // memory always ready, long latency: block's own limit
        limit_en = 0; lat = 50;
        launch_run(32'h0002_0000, 200);
        finish_run("R1 limit");
        check(max_out == LIMIT, "R1", "peak in-flight requests", 64'(max_out), 64'(LIMIT));
        limit_en = 1; lat = 2;

        // start during a run is ignored
        p_dready = 30;
        launch_run(32'h0003_0000, 120);
        repeat (20) @(negedge clk);
        base_addr = 32'h0BAD_0000; elem_count = 16'd5; start = 1;
        @(negedge clk);
        start = 0;
        finish_run("R10 restart ignored");
        p_dready = 100;

        // mid-run reset, then a clean run
        p_dready = 40;
        launch_run(32'h0004_0000, 100);
        repeat (40) @(negedge clk);
        rst_n = 0;
        q_addr.delete(); q_due.delete(); outstanding = 0;
        repeat (2) @(negedge clk);
        #2;
        check(!mem_req_valid && !dma_valid && !done, "R11", "mid-run reset state",
              {61'd0, mem_req_valid, dma_valid, done}, 64'd0);
        @(negedge clk);
        rst_n = 1;
        launch_run(32'h0005_0000, 20);
        finish_run("R11 after reset");
        p_dready = 100;

        // constrained random runs
        for (int k = 0; k < 6; k++) begin
            p_mready = 30 + $urandom % 71;
            p_dready = 20 + $urandom % 81;
            p_ret    = 30 + $urandom % 71;
            lat      = 1 + $urandom % 12;
            launch_run($urandom, 1 + int'($urandom % 150));
            finish_run("R2 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule